// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block decides which clock domains of a small processor system are running. The CPU issues a power-save request whose operand selects one of two depths. Idle stops only the CPU clock and leaves the peripherals and the main oscillator running. Sleep stops the CPU clock, the system-clocked peripherals and the main oscillator. Before Sleep, the watchdog is cleared if it is armed. The low-speed watchdog clock keeps running through Sleep whenever the watchdog is armed. The clock-failure monitor is held off while the system clock is deliberately stopped.

The block returns to Run on any of three events: an interrupt that is both pending and enabled, a watchdog time-out, or a reset. When it wakes from Sleep, it first passes through a Waking state. There the oscillator runs again but the CPU and peripheral clocks stay off for a programmable number of cycles. The clock-source selection that was active when Sleep was requested is held on the output through the whole low-power period, so the system restarts on that same source.

The power-save request uses a valid/ready handshake. `req_ready` is high only in Run. The requester holds `req_valid` and `req_is_sleep` steady until a clock edge sees both valid and ready; while ready is low the request waits and has no effect. All other pins are plain level signals.

Top module: `pm_power_ctrl`

## Requirements
- R1: `req_ready` is 1 exactly when the mode is Run. A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_is_sleep`=1 selects Sleep and 0 selects Idle.
- R2: In Idle, `mode_status`=2'b01, `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R3: An accepted Sleep request first gives one preparation cycle. In that cycle `mode_status`=2'b10, `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1, and `wdt_clr` equals `wdt_enabled`. After it comes Sleep, with `mode_status`=2'b10, `wdt_clr`=0, and `cpu_clk_en`, `per_clk_en` and `osc_en` all 0.
- R4: The wake condition is the OR-reduction of (`irq_pending` AND `irq_enable`), ORed with `wdt_timeout`. A pending interrupt whose enable bit is 0 causes no wake-up.
- R5: In Idle, a wake condition seen at a clock edge returns the block to Run (`mode_status`=2'b00, `cpu_clk_en`=1) at that edge.
- R6: In Sleep, a wake condition seen at an edge moves the block to Waking: `mode_status`=2'b11, `osc_en`=1, `cpu_clk_en`=0, `per_clk_en`=0. Waking lasts max(`settle_cycles`,1) cycles and then the block is in Run.
- R7: `lprc_en` equals `wdt_enabled` in Sleep and is 1 in every other mode.
- R8: `fscm_en` is 0 in Sleep and in Waking, and 1 otherwise (the preparation cycle included).
- R9: In Run, `clk_sel_out` takes the value of `clk_sel_in` at each clock edge. From the edge that accepts a Sleep request until the first Run cycle after wake-up, `clk_sel_out` holds the value it captured at the accepting edge, whatever `clk_sel_in` does.
- R10: `rst_n`=0 forces Run at once (asynchronously). During reset `cpu_clk_en`, `per_clk_en`, `osc_en`, `lprc_en` and `fscm_en` are all 1, `clk_sel_out`=0 and `wake_pulse`=0. A request held during reset is not taken.
- R11: `wake_pulse` is 1 for exactly the first Run cycle that follows Idle, Sleep, Waking or the preparation cycle, and is 0 at all other times.
- R12: A wake condition in the preparation cycle returns the block straight to Run without stopping the oscillator, and `wake_pulse` fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Power-save request valid |
| req_ready | output | 1 | Request can be accepted (Run only) |
| req_is_sleep | input | 1 | Request operand: 1 Sleep, 0 Idle |
| irq_pending | input | N_IRQ | Pending interrupt flags |
| irq_enable | input | N_IRQ | Per-interrupt enables |
| wdt_enabled | input | 1 | Watchdog is armed |
| wdt_timeout | input | 1 | Watchdog time-out event |
| wdt_clr | output | 1 | Watchdog clear pulse before Sleep |
| settle_cycles | input | CW | Oscillator settling cycles on wake from Sleep |
| clk_sel_in | input | SW | Requested system clock source |
| clk_sel_out | output | SW | Clock source to apply, held across Sleep |
| cpu_clk_en | output | 1 | CPU clock domain enable |
| per_clk_en | output | 1 | Peripheral clock domain enable |
| osc_en | output | 1 | Main oscillator enable |
| lprc_en | output | 1 | Low-speed watchdog clock enable |
| fscm_en | output | 1 | Clock-failure monitor enable |
| mode_status | output | 2 | 00 Run, 01 Idle, 10 Sleep, 11 Waking |
| wake_pulse | output | 1 | One-cycle pulse on completed wake-up |

## Verification
The hardest situation to reach is a wake condition that arrives during the single preparation cycle between an accepted Sleep request and Sleep itself. The bench gets there by raising an enabled interrupt on the same cycle it presents the Sleep request, so the condition is already present at the first edge after acceptance. The Waking length is swept over several settle counts, and the clock source is changed while asleep to show that the held value is kept. The Idle wake qualification is swept over every pending and enable combination of a four-interrupt configuration.

// File: rtl/pm_power_pkg.sv
package pm_power_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_PREP,
    ST_SLEEP,
    ST_WAKE
  } pm_state_e;

  typedef enum logic [1:0] {
    MS_RUN    = 2'b00,
    MS_IDLE   = 2'b01,
    MS_SLEEP  = 2'b10,
    MS_WAKING = 2'b11
  } pm_status_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
    logic lprc;
    logic fscm;
  } pm_gates_t;

  function automatic pm_gates_t gates_for(pm_state_e s, logic wdt_on);
    pm_gates_t g;
    g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, lprc: 1'b1, fscm: 1'b1};
    case (s)
      ST_IDLE:  g.cpu = 1'b0;
      ST_PREP:  g.cpu = 1'b0;
      ST_SLEEP: begin
        g.cpu  = 1'b0;
        g.per  = 1'b0;
        g.osc  = 1'b0;
        g.lprc = wdt_on;
        g.fscm = 1'b0;
      end
      ST_WAKE: begin
        g.cpu  = 1'b0;
        g.per  = 1'b0;
        g.fscm = 1'b0;
      end
      default: ;
    endcase
    return g;
  endfunction

  function automatic pm_status_e status_for(pm_state_e s);
    case (s)
      ST_IDLE:  return MS_IDLE;
      ST_PREP:  return MS_SLEEP;
      ST_SLEEP: return MS_SLEEP;
      ST_WAKE:  return MS_WAKING;
      default:  return MS_RUN;
    endcase
  endfunction

endpackage

// File: rtl/pm_wake_qual.sv
module pm_wake_qual #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_pending,
  input  logic [N_IRQ-1:0] irq_enable,
  input  logic             wdt_timeout,
  output logic             irq_hit,
  output logic             wake
);
  logic [N_IRQ-1:0] masked;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
    assign masked[i] = irq_pending[i] & irq_enable[i];
  end

  assign irq_hit = |masked;
  assign wake    = irq_hit | wdt_timeout;
endmodule

// File: rtl/pm_settle_cnt.sv
module pm_settle_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign done     = active && (cnt_next >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (!done)   cnt <= cnt_next[CW-1:0];
  end

  assert_settle_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && limit > 1) |-> (cnt < limit));
endmodule

// File: rtl/pm_clksel_hold.sv
module pm_clksel_hold #(
  parameter int          SW        = 2,
  parameter logic [SW-1:0] RESET_SEL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          track,
  input  logic [SW-1:0] sel_in,
  output logic [SW-1:0] sel_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_out <= RESET_SEL;
    else if (track) sel_out <= sel_in;
  end
endmodule

// File: rtl/pm_power_ctrl.sv
module pm_power_ctrl
  import pm_power_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int CW    = 8,
  parameter int SW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_sleep,
  input  logic [N_IRQ-1:0] irq_pending,
  input  logic [N_IRQ-1:0] irq_enable,
  input  logic             wdt_enabled,
  input  logic             wdt_timeout,
  output logic             wdt_clr,
  input  logic [CW-1:0]    settle_cycles,
  input  logic [SW-1:0]    clk_sel_in,
  output logic [SW-1:0]    clk_sel_out,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             lprc_en,
  output logic             fscm_en,
  output logic [1:0]       mode_status,
  output logic             wake_pulse
);
  localparam logic [SW-1:0] SEL_AT_RESET = '0;

  pm_state_e state, nxt;
  pm_gates_t gates;
  logic      wake, irq_hit, settle_done, accept;

  pm_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .wdt_timeout (wdt_timeout),
    .irq_hit     (irq_hit),
    .wake        (wake)
  );

  pm_settle_cnt #(.CW(CW)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state == ST_WAKE),
    .limit  (settle_cycles),
    .done   (settle_done)
  );

  pm_clksel_hold #(.SW(SW), .RESET_SEL(SEL_AT_RESET)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .track   (state == ST_RUN),
    .sel_in  (clk_sel_in),
    .sel_out (clk_sel_out)
  );

  assign req_ready = (state == ST_RUN);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:   if (accept) nxt = req_is_sleep ? ST_PREP : ST_IDLE;
      ST_IDLE:  if (wake) nxt = ST_RUN;
      ST_PREP:  nxt = wake ? ST_RUN : ST_SLEEP;
      ST_SLEEP: if (wake) nxt = ST_WAKE;
      ST_WAKE:  if (settle_done) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      wake_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      wake_pulse <= (nxt == ST_RUN) && (state != ST_RUN);
    end
  end

  assign gates       = gates_for(state, wdt_enabled);
  assign cpu_clk_en  = gates.cpu;
  assign per_clk_en  = gates.per;
  assign osc_en      = gates.osc;
  assign lprc_en     = gates.lprc;
  assign fscm_en     = gates.fscm;
  assign mode_status = status_for(state);
  assign wdt_clr     = (state == ST_PREP) && wdt_enabled;

  assert_ready_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cpu_clk_en);

  assert_sleep_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_is_sleep) |=> (wdt_clr == $past(wdt_enabled)));

  assert_osc_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> ($past(state) == ST_PREP));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !irq_hit && !wdt_timeout) |=> (mode_status == MS_IDLE));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && $past(state) != ST_RUN) |-> $stable(clk_sel_out));

  assert_cpu_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake_pulse);
endmodule

// File: tb/tb_pm_power_ctrl.sv
module tb_pm_power_ctrl;
  localparam int N = 4;
  localparam int CW = 8;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_sleep = 1'b0;
  logic [N-1:0] irq_pending = '0, irq_enable = '0;
  logic wdt_enabled = 1'b0, wdt_timeout = 1'b0;
  logic [CW-1:0] settle_cycles = '0;
  logic [SW-1:0] clk_sel_in = '0;
  logic req_ready, wdt_clr, cpu_clk_en, per_clk_en, osc_en, lprc_en, fscm_en, wake_pulse;
  logic [SW-1:0] clk_sel_out;
  logic [1:0] mode_status;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pm_power_ctrl #(.N_IRQ(N), .CW(CW), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_sleep(req_is_sleep), .irq_pending(irq_pending), .irq_enable(irq_enable),
    .wdt_enabled(wdt_enabled), .wdt_timeout(wdt_timeout), .wdt_clr(wdt_clr),
    .settle_cycles(settle_cycles), .clk_sel_in(clk_sel_in), .clk_sel_out(clk_sel_out),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .lprc_en(lprc_en), .fscm_en(fscm_en), .mode_status(mode_status),
    .wake_pulse(wake_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic all_on(input string tag);
    chk({tag, " mode"}, mode_status, 0);
    chk({tag, " cpu"}, cpu_clk_en, 1);
    chk({tag, " per"}, per_clk_en, 1);
    chk({tag, " osc"}, osc_en, 1);
    chk({tag, " lprc"}, lprc_en, 1);
    chk({tag, " fscm"}, fscm_en, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R10: reset state, with a request held during reset
    req_valid = 1'b1;
    req_is_sleep = 1'b1;
    repeat (3) @(negedge clk);
    all_on("R10 reset");
    chk("R10 sel", clk_sel_out, 0);
    chk("R10 pulse", wake_pulse, 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    step();
    all_on("R10 after release");

    // R9: tracking in Run
    clk_sel_in = 2'd2;
    step();
    chk("R9 track", clk_sel_out, 2);

    // R2 R4 R5 R11: Idle wake sweep over all pending/enable combinations
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        int exp_w;
        exp_w = ((p & e) != 0) ? 1 : 0;
        chk("R1 ready in run", req_ready, 1);
        req_valid = 1'b1;
        req_is_sleep = 1'b0;
        step();
        req_valid = 1'b0;
        chk("R2 idle mode", mode_status, 1);
        chk("R2 idle cpu", cpu_clk_en, 0);
        chk("R2 idle per", per_clk_en, 1);
        chk("R2 idle osc", osc_en, 1);
        chk("R1 ready low", req_ready, 0);
        irq_pending = p[N-1:0];
        irq_enable = e[N-1:0];
        step();
        chk("R4 R5 idle wake mode", mode_status, exp_w ? 0 : 1);
        chk("R11 pulse", wake_pulse, exp_w);
        if (exp_w == 0) begin
          irq_pending = '0;
          wdt_timeout = 1'b1;
          step();
          chk("R4 timeout wake", mode_status, 0);
          chk("R11 pulse timeout", wake_pulse, 1);
          wdt_timeout = 1'b0;
        end
        irq_pending = '0;
        irq_enable = '0;
        step();
        chk("R11 pulse single", wake_pulse, 0);
      end
    end

    // R3 R6 R7 R8 R9: Sleep sweep over settle counts and watchdog arming
    for (int s = 0; s < 6; s++) begin
      for (int w = 0; w < 2; w++) begin
        int len;
        len = (s < 1) ? 1 : s;
        settle_cycles = s[CW-1:0];
        wdt_enabled = w[0];
        clk_sel_in = 2'd1;
        step();
        req_valid = 1'b1;
        req_is_sleep = 1'b1;
        step();
        req_valid = 1'b0;
        chk("R3 prep mode", mode_status, 2);
        chk("R3 prep clr", wdt_clr, w);
        chk("R3 prep cpu", cpu_clk_en, 0);
        chk("R3 prep per", per_clk_en, 1);
        chk("R3 prep osc", osc_en, 1);
        chk("R8 prep fscm", fscm_en, 1);
        clk_sel_in = 2'd3;
        step();
        chk("R3 sleep mode", mode_status, 2);
        chk("R3 sleep clr", wdt_clr, 0);
        chk("R3 sleep cpu", cpu_clk_en, 0);
        chk("R3 sleep per", per_clk_en, 0);
        chk("R3 sleep osc", osc_en, 0);
        chk("R7 sleep lprc", lprc_en, w);
        chk("R8 sleep fscm", fscm_en, 0);
        chk("R9 sleep hold", clk_sel_out, 1);
        irq_pending = '1;
        irq_enable = '0;
        step();
        chk("R4 masked no wake", mode_status, 2);
        irq_pending = '0;
        if (s % 2 == 1) wdt_timeout = 1'b1;
        else begin
          irq_pending = 4'b0100;
          irq_enable = 4'b0110;
        end
        step();
        wdt_timeout = 1'b0;
        irq_pending = '0;
        irq_enable = '0;
        for (int k = 0; k < len; k++) begin
          chk("R6 waking mode", mode_status, 3);
          chk("R6 waking osc", osc_en, 1);
          chk("R6 waking cpu", cpu_clk_en, 0);
          chk("R6 waking per", per_clk_en, 0);
          chk("R8 waking fscm", fscm_en, 0);
          chk("R7 waking lprc", lprc_en, 1);
          chk("R9 waking hold", clk_sel_out, 1);
          step();
        end
        chk("R6 run after settle", mode_status, 0);
        chk("R6 cpu on", cpu_clk_en, 1);
        chk("R11 pulse sleep", wake_pulse, 1);
        chk("R9 restored", clk_sel_out, 1);
        step();
        chk("R9 track again", clk_sel_out, 3);
        chk("R11 pulse drop", wake_pulse, 0);
      end
    end

    // R12: wake condition present during the preparation cycle
    wdt_enabled = 1'b1;
    irq_pending = 4'b0001;
    irq_enable = 4'b0001;
    req_valid = 1'b1;
    req_is_sleep = 1'b1;
    step();
    req_valid = 1'b0;
    chk("R12 prep mode", mode_status, 2);
    chk("R12 prep clr", wdt_clr, 1);
    step();
    chk("R12 back to run", mode_status, 0);
    chk("R12 osc kept", osc_en, 1);
    chk("R12 pulse", wake_pulse, 1);
    irq_pending = '0;
    irq_enable = '0;
    step();

    // R10: asynchronous reset from Sleep
    req_valid = 1'b1;
    req_is_sleep = 1'b1;
    step();
    req_valid = 1'b0;
    step();
    chk("R10 in sleep", osc_en, 0);
    rst_n = 1'b0;
    #1;
    all_on("R10 async");
    chk("R10 sel async", clk_sel_out, 0);
    step();
    rst_n = 1'b1;
    step();
    all_on("R10 released");

    summary();
  end
endmodule